// File: doc/BRIEF.md
# Variable-Length Instruction Byte Decoder

This block turns a stream of instruction bytes into one decoded instruction record at a time. Bytes arrive one per cycle over a valid/ready input. The first byte of every instruction is the opcode. Depending on the opcode, zero, one or two parameter bytes follow. If the source parameter is an immediate, the immediate bytes come last, least-significant byte first. The decoder works out the parameter count and the addressing mode from the opcode. It splits register parameters into a register selector and a sub-register selector, reads the immediate-size descriptor, assembles the immediate, and counts the bytes the instruction occupied.

The finished record sits on a valid/ready output. Back-pressure follows two rules:
- A record stays on the output, unchanged, for as long as `out_valid` is high and `out_ready` is low.
- While a record is held, `in_ready` is low and no byte is taken.

The decoder returns to fetching an opcode only in the cycle after the consumer accepts the record. A low `in_valid` stalls parsing without side effects. Opcodes that are not assigned, and immediate descriptors that cannot be honoured, complete early with the illegal flag set. An instruction fetch unit typically feeds the decoder and an execution stage drains it.

Top module: `instr_byte_decoder`

## Requirements
- R1: A synchronous reset, at start-up or in the middle of an instruction, leaves the block with `in_ready` = 1 and `out_valid` = 0, waiting for an opcode byte.
- R2: For an opcode byte with bit 5 clear, bits 4:0 are the base opcode, bit 6 set marks the source as an immediate and bit 7 set marks it as a memory pointer. `out_opcode` always reports the raw opcode byte.
- R3: The parameter count comes from the opcode. Base 0x01, 0x02, 0x03–0x10, 0x1E and 0x1F take two. Base 0x11–0x13 and 0x15–0x1D take one. Base 0x00 takes none. An instruction with no parameters completes after one byte.
- R4: These opcodes are illegal: base 0x00, 0x02 or 0x11–0x13 with any mode bit set, base 0x14, and any bit-5 opcode not listed in R11. An illegal opcode completes after one byte with `out_illegal` = 1, and every other field is zero except `out_opcode` and `out_length`.
- R5: A register parameter byte carries the register in bits 7:4 and the sub-register in bits 3:0. With two parameters the first is the source and the second the destination. A lone parameter is reported in the source fields.
- R6: For an immediate source, the first parameter byte is a size descriptor: code bits 1:0 = 0, 1, 2, 3 give 1, 2, 4, 8 bytes. A descriptor with bit 2 or bit 3 set makes the instruction illegal; it completes after that byte with no immediate.
- R7: Immediate bytes follow all parameter bytes, arrive least-significant first, and are reported zero-extended to 64 bits. `out_imm` is zero when there is no immediate.
- R8: `out_length` equals the number of bytes the instruction consumed: one, plus the parameter bytes, plus the immediate bytes.
- R9: While `out_valid` is high and `out_ready` is low, every record field is held and `in_ready` is low. After acceptance, the next opcode byte can be taken one cycle later.
- R10: A cycle without an input handshake changes no decode progress, and the byte on `in_byte` in such a cycle is ignored.
- R11: With bit 5 set, the whole byte is the opcode and has no mode flags. The opcodes are:
  - 0x27, 0x28, 0x29, 0x30, 0x31, 0x32, 0xAA and 0xFF take no parameters.
  - 0x20, 0x22, 0x24 and 0x26 take one register.
  - 0x60 and 0x64 take one immediate.
  - 0x23 and 0x25 take two registers.
  - 0x63 and 0x65 take an immediate source and a register destination.
  - `out_src_ptr` is 0 for all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte present |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Raw opcode byte |
| out_illegal | output | 1 | Reserved opcode or unusable size descriptor |
| out_src_imm | output | 1 | Source is an immediate |
| out_src_ptr | output | 1 | Source is a memory pointer |
| out_param_cnt | output | 2 | Number of parameter bytes the opcode calls for |
| out_src_reg | output | 4 | Source register selector |
| out_src_sub | output | 4 | Source sub-register selector |
| out_dst_reg | output | 4 | Destination register selector |
| out_dst_sub | output | 4 | Destination sub-register selector |
| out_has_imm | output | 1 | An immediate was read |
| out_imm_size | output | 2 | Immediate size code (bytes = 1 << code) |
| out_imm | output | 8*IMM_BYTES | Zero-extended immediate |
| out_length | output | LEN_W | Instruction length in bytes |

## Verification
The checker watches properties on every cycle:
- that a held record does not move while back-pressured, and that intake is closed during the hold;
- that no record appears without an input handshake;
- that the reported length agrees with the parameter count and the immediate size;
- that immediates are zero-extended, and that illegal records are short;
- that the mode flags follow the opcode's bit 5.

Whether a given opcode gets the right parameter count, whether the register nibbles land in the right fields, and whether bytes are placed little-endian can only be shown by the bench's instruction scenarios. The same goes for stalls and back-pressure patterns and a reset in mid-instruction. The bench compares those against its transaction model on every clock.

// File: rtl/ibd_pkg.sv
package ibd_pkg;

  typedef enum logic [2:0] {
    ST_OPC  = 3'd0,
    ST_SRC  = 3'd1,
    ST_DST  = 3'd2,
    ST_IMM  = 3'd3,
    ST_HOLD = 3'd4
  } dec_state_e;

  typedef struct packed {
    logic       legal;
    logic [1:0] nparams;
    logic       src_imm;
    logic       src_ptr;
  } op_class_t;

  localparam logic [4:0] BASE_HALT     = 5'h00;
  localparam logic [4:0] BASE_STORE    = 5'h02;
  localparam logic [4:0] BASE_UNARY_LO = 5'h11;
  localparam logic [4:0] BASE_UNARY_HI = 5'h13;
  localparam logic [4:0] BASE_PORTIMM  = 5'h14;
  localparam logic [4:0] BASE_FLOW_LO  = 5'h15;
  localparam logic [4:0] BASE_FLOW_HI  = 5'h1D;

endpackage

// File: rtl/ibd_opclass.sv
module ibd_opclass
  import ibd_pkg::*;
(
  input  logic [7:0] opcode,
  output op_class_t  cls
);

  logic [4:0] base;
  logic       flagged;

  assign base    = opcode[4:0];
  assign flagged = opcode[7] | opcode[6];

  always_comb begin
    cls = '0;
    if (!opcode[5]) begin
      cls.legal   = 1'b1;
      cls.src_imm = opcode[6];
      cls.src_ptr = opcode[7];
      if (base == BASE_HALT) begin
        cls.legal   = !flagged;
        cls.nparams = 2'd0;
      end else if (base == BASE_STORE) begin
        cls.legal   = !flagged;
        cls.nparams = 2'd2;
      end else if (base >= BASE_UNARY_LO && base <= BASE_UNARY_HI) begin
        cls.legal   = !flagged;
        cls.nparams = 2'd1;
      end else if (base == BASE_PORTIMM) begin
        cls.legal = 1'b0;
      end else if (base >= BASE_FLOW_LO && base <= BASE_FLOW_HI) begin
        cls.nparams = 2'd1;
      end else begin
        cls.nparams = 2'd2;
      end
    end else begin
      cls.legal = 1'b1;
      case (opcode)
        8'h27, 8'h28, 8'h29, 8'h30,
        8'h31, 8'h32, 8'hAA, 8'hFF: cls.nparams = 2'd0;
        8'h20, 8'h22, 8'h24, 8'h26: cls.nparams = 2'd1;
        8'h60, 8'h64: begin
          cls.nparams = 2'd1;
          cls.src_imm = 1'b1;
        end
        8'h23, 8'h25: cls.nparams = 2'd2;
        8'h63, 8'h65: begin
          cls.nparams = 2'd2;
          cls.src_imm = 1'b1;
        end
        default: cls.legal = 1'b0;
      endcase
    end
    if (!cls.legal) begin
      cls.nparams = 2'd0;
      cls.src_imm = 1'b0;
      cls.src_ptr = 1'b0;
    end
  end

endmodule

// File: rtl/ibd_desc_check.sv
module ibd_desc_check #(
  parameter int IMM_BYTES = 8
) (
  input  logic [3:0] desc,
  output logic       ok,
  output logic [1:0] size_code
);

  int unsigned nbytes;

  always_comb begin
    size_code = desc[1:0];
    nbytes    = 32'd1 << desc[1:0];
    ok        = !desc[3] && !desc[2] && (nbytes <= IMM_BYTES);
  end

endmodule

// File: rtl/ibd_imm_gather.sv
module ibd_imm_gather #(
  parameter int IMM_BYTES = 8,
  localparam int IDX_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   load,
  input  logic [IDX_W-1:0]       lane,
  input  logic [7:0]             din,
  output logic [8*IMM_BYTES-1:0] value
);

  for (genvar i = 0; i < IMM_BYTES; i++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        lane_q <= 8'h00;
      end else if (load && lane == IDX_W'(i)) begin
        lane_q <= din;
      end
    end
    assign value[8*i +: 8] = lane_q;
  end

endmodule

// File: rtl/instr_byte_decoder.sv
module instr_byte_decoder
  import ibd_pkg::*;
#(
  parameter int IMM_BYTES = 8,
  localparam int IMM_W = 8 * IMM_BYTES,
  localparam int LEN_W = $clog2(IMM_BYTES + 4)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_opcode,
  output logic             out_illegal,
  output logic             out_src_imm,
  output logic             out_src_ptr,
  output logic [1:0]       out_param_cnt,
  output logic [3:0]       out_src_reg,
  output logic [3:0]       out_src_sub,
  output logic [3:0]       out_dst_reg,
  output logic [3:0]       out_dst_sub,
  output logic             out_has_imm,
  output logic [1:0]       out_imm_size,
  output logic [IMM_W-1:0] out_imm,
  output logic [LEN_W-1:0] out_length
);

  localparam int IDX_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;

  dec_state_e       state_q;
  op_class_t        cls_now;
  logic             desc_ok;
  logic [1:0]       desc_code;
  logic [IDX_W-1:0] lane_q;
  logic [IDX_W-1:0] lane_last;
  logic             take;

  logic [7:0]       op_q;
  logic             ill_q, simm_q, sptr_q, has_q;
  logic [1:0]       np_q, size_q;
  logic [3:0]       sreg_q, ssub_q, dreg_q, dsub_q;
  logic [LEN_W-1:0] len_q;

  assign in_ready  = (state_q != ST_HOLD);
  assign out_valid = (state_q == ST_HOLD);
  assign take      = in_valid && in_ready;
  assign lane_last = IDX_W'((32'd1 << size_q) - 32'd1);

  ibd_opclass u_class (
    .opcode (in_byte),
    .cls    (cls_now)
  );

  ibd_desc_check #(.IMM_BYTES(IMM_BYTES)) u_desc (
    .desc      (in_byte[3:0]),
    .ok        (desc_ok),
    .size_code (desc_code)
  );

  ibd_imm_gather #(.IMM_BYTES(IMM_BYTES)) u_imm (
    .clk   (clk),
    .rst   (rst),
    .clear (take && state_q == ST_OPC),
    .load  (take && state_q == ST_IMM),
    .lane  (lane_q),
    .din   (in_byte),
    .value (out_imm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OPC;
      op_q    <= 8'h00;
      ill_q   <= 1'b0;
      simm_q  <= 1'b0;
      sptr_q  <= 1'b0;
      has_q   <= 1'b0;
      np_q    <= 2'd0;
      size_q  <= 2'd0;
      sreg_q  <= 4'h0;
      ssub_q  <= 4'h0;
      dreg_q  <= 4'h0;
      dsub_q  <= 4'h0;
      len_q   <= '0;
      lane_q  <= '0;
    end else begin
      case (state_q)
        ST_OPC: if (in_valid) begin
          op_q   <= in_byte;
          len_q  <= LEN_W'(1);
          sreg_q <= 4'h0;
          ssub_q <= 4'h0;
          dreg_q <= 4'h0;
          dsub_q <= 4'h0;
          size_q <= 2'd0;
          has_q  <= 1'b0;
          lane_q <= '0;
          ill_q  <= !cls_now.legal;
          np_q   <= cls_now.nparams;
          simm_q <= cls_now.src_imm;
          sptr_q <= cls_now.src_ptr;
          if (!cls_now.legal || cls_now.nparams == 2'd0) begin
            state_q <= ST_HOLD;
          end else begin
            state_q <= ST_SRC;
          end
        end
        ST_SRC: if (in_valid) begin
          len_q <= len_q + LEN_W'(1);
          if (simm_q) begin
            if (!desc_ok) begin
              ill_q   <= 1'b1;
              state_q <= ST_HOLD;
            end else begin
              size_q  <= desc_code;
              has_q   <= 1'b1;
              state_q <= (np_q == 2'd2) ? ST_DST : ST_IMM;
            end
          end else begin
            sreg_q  <= in_byte[7:4];
            ssub_q  <= in_byte[3:0];
            state_q <= (np_q == 2'd2) ? ST_DST : ST_HOLD;
          end
        end
        ST_DST: if (in_valid) begin
          len_q   <= len_q + LEN_W'(1);
          dreg_q  <= in_byte[7:4];
          dsub_q  <= in_byte[3:0];
          state_q <= simm_q ? ST_IMM : ST_HOLD;
        end
        ST_IMM: if (in_valid) begin
          len_q  <= len_q + LEN_W'(1);
          lane_q <= lane_q + IDX_W'(1);
          if (lane_q == lane_last) begin
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: if (out_ready) begin
          state_q <= ST_OPC;
        end
        default: state_q <= ST_OPC;
      endcase
    end
  end

  assign out_opcode    = op_q;
  assign out_illegal   = ill_q;
  assign out_src_imm   = simm_q;
  assign out_src_ptr   = sptr_q;
  assign out_param_cnt = np_q;
  assign out_src_reg   = sreg_q;
  assign out_src_sub   = ssub_q;
  assign out_dst_reg   = dreg_q;
  assign out_dst_sub   = dsub_q;
  assign out_has_imm   = has_q;
  assign out_imm_size  = size_q;
  assign out_length    = len_q;

endmodule

// File: rtl/ibd_checker.sv
module ibd_checker #(
  parameter int IMM_BYTES = 8,
  localparam int IMM_W = 8 * IMM_BYTES,
  localparam int LEN_W = $clog2(IMM_BYTES + 4)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_opcode,
  input logic             out_illegal,
  input logic             out_src_imm,
  input logic             out_src_ptr,
  input logic [1:0]       out_param_cnt,
  input logic             out_has_imm,
  input logic [1:0]       out_imm_size,
  input logic [IMM_W-1:0] out_imm,
  input logic [LEN_W-1:0] out_length
);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_imm)
      && $stable(out_length) && $stable(out_illegal) && $stable(out_param_cnt));

  assert_no_intake_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_no_record_without_byte_R10: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) && !out_valid |=> !out_valid);

  assert_bare_opcode_len_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_illegal && out_param_cnt == 2'd0 |-> out_length == LEN_W'(1));

  assert_illegal_short_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_length <= LEN_W'(2) && !out_has_imm);

  assert_length_sum_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_illegal |-> int'(out_length) ==
      1 + int'(out_param_cnt) + (out_has_imm ? (1 << out_imm_size) : 0));

  assert_zero_extend_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_has_imm |-> out_imm == '0);

  assert_mode_flags_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_illegal && !out_opcode[5] |->
      out_src_imm == out_opcode[6] && out_src_ptr == out_opcode[7]);

  assert_full_opcode_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_src_ptr |-> !out_opcode[5]);

endmodule

bind instr_byte_decoder ibd_checker #(.IMM_BYTES(IMM_BYTES)) u_ibd_checker (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_opcode    (out_opcode),
  .out_illegal   (out_illegal),
  .out_src_imm   (out_src_imm),
  .out_src_ptr   (out_src_ptr),
  .out_param_cnt (out_param_cnt),
  .out_has_imm   (out_has_imm),
  .out_imm_size  (out_imm_size),
  .out_imm       (out_imm),
  .out_length    (out_length)
);

// File: tb/tb_instr_byte_decoder.sv
module tb_instr_byte_decoder;
  localparam int IMM_BYTES = 8;
  localparam int LEN_W = $clog2(IMM_BYTES + 4);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [7:0] in_byte = 8'h00, out_opcode;
  logic out_illegal, out_src_imm, out_src_ptr, out_has_imm;
  logic [1:0] out_param_cnt, out_imm_size;
  logic [3:0] out_src_reg, out_src_sub, out_dst_reg, out_dst_sub;
  logic [63:0] out_imm;
  logic [LEN_W-1:0] out_length;

  instr_byte_decoder #(.IMM_BYTES(IMM_BYTES)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
    .out_illegal(out_illegal), .out_src_imm(out_src_imm), .out_src_ptr(out_src_ptr),
    .out_param_cnt(out_param_cnt), .out_src_reg(out_src_reg), .out_src_sub(out_src_sub),
    .out_dst_reg(out_dst_reg), .out_dst_sub(out_dst_sub), .out_has_imm(out_has_imm),
    .out_imm_size(out_imm_size), .out_imm(out_imm), .out_length(out_length)
  );

  typedef struct {
    logic [7:0]  op;
    bit          ill;
    int          np;
    bit          simm;
    bit          sptr;
    int          sreg, ssub, dreg, dsub, size;
    bit          has;
    logic [63:0] imm;
    int          len;
  } exp_t;

  logic [7:0] stream[$];
  exp_t       expq[$];
  int total = 0, bad = 0, cyc = 0, records = 0, m_acc = 0;
  int in_mode = 0, out_mode = 0;
  bit m_outv = 1'b0, finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic void ref_class(input logic [7:0] op, output bit legal, output int np,
                                    output bit simm, output bit sptr);
    int  b;
    bit  flagged;
    b = int'(op[4:0]);
    flagged = (op[7:6] != 2'b00);
    legal = 1; np = 0; simm = 0; sptr = 0;
    if (op[5]) begin
      simm = op inside {8'h60, 8'h63, 8'h64, 8'h65};
      if (op inside {8'h27, 8'h28, 8'h29, 8'h30, 8'h31, 8'h32, 8'hAA, 8'hFF}) np = 0;
      else if (op inside {8'h20, 8'h22, 8'h24, 8'h26, 8'h60, 8'h64}) np = 1;
      else if (op inside {8'h23, 8'h25, 8'h63, 8'h65}) np = 2;
      else legal = 0;
    end else begin
      simm = op[6];
      sptr = op[7];
      if (b == 0) legal = !flagged;
      else if (b == 2) begin legal = !flagged; np = 2; end
      else if (b >= 17 && b <= 19) begin legal = !flagged; np = 1; end
      else if (b == 20) legal = 0;
      else if (b >= 21 && b <= 29) np = 1;
      else np = 2;
    end
    if (!legal) begin np = 0; simm = 0; sptr = 0; end
  endfunction

  task automatic add(input logic [7:0] q[$]);
    exp_t e;
    bit legal;
    int pos;
    e = '{op: q[0], ill: 0, np: 0, simm: 0, sptr: 0, sreg: 0, ssub: 0, dreg: 0, dsub: 0,
          size: 0, has: 0, imm: 64'h0, len: 1};
    ref_class(q[0], legal, e.np, e.simm, e.sptr);
    e.ill = !legal;
    pos = 1;
    if (legal && e.np >= 1) begin
      if (e.simm) begin
        if (q[1][3] || q[1][2]) e.ill = 1;
        else begin e.has = 1; e.size = int'(q[1][1:0]); end
      end else begin
        e.sreg = int'(q[1][7:4]); e.ssub = int'(q[1][3:0]);
      end
      pos = 2;
      if (!e.ill && e.np == 2) begin
        e.dreg = int'(q[2][7:4]); e.dsub = int'(q[2][3:0]);
        pos = 3;
      end
      if (e.has) begin
        for (int i = 0; i < (1 << e.size); i++) e.imm[8*i +: 8] = q[pos + i];
        pos = pos + (1 << e.size);
      end
    end
    e.len = pos;
    for (int i = 0; i < pos; i++) stream.push_back(q[i]);
    expq.push_back(e);
  endtask

  task automatic add_all();
    add('{8'h41, 8'h02, 8'h3E, 8'h11, 8'h44, 8'hCC, 8'hFF});
    add('{8'h00});
    add('{8'h01, 8'h12, 8'h3E});
    add('{8'h81, 8'h2C, 8'h0E});
    add('{8'hC3, 8'h03, 8'h5E, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h88});
    add('{8'h56, 8'h01, 8'h34, 8'h12});
    add('{8'h11, 8'h4E});
    add('{8'h40});
    add('{8'h14});
    add('{8'h41, 8'h0A});
    add('{8'h41, 8'h04});
    add('{8'hAA});
    add('{8'hFF});
    add('{8'h27});
    add('{8'h60, 8'h00, 8'h7F});
    add('{8'h63, 8'h02, 8'h1E, 8'hAA, 8'hBB, 8'hCC, 8'hDD});
    add('{8'h33});
    add('{8'h2A});
    add('{8'h22, 8'h5E});
    add('{8'hD7, 8'h03, 8'hF0, 8'hDE, 8'hBC, 8'h9A, 8'h78, 8'h56, 8'h34, 8'h12});
    add('{8'h64, 8'h00, 8'h80});
    add('{8'h1F, 8'hA9, 8'hBC});
  endtask

  // transaction model, advanced at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_outv = 1'b0;
      m_acc  = 0;
    end else if (m_outv) begin
      if (out_ready) begin
        m_outv = 1'b0;
        m_acc  = 0;
        records++;
        if (expq.size() > 0) void'(expq.pop_front());
      end
    end else if (in_valid) begin
      if (stream.size() > 0) void'(stream.pop_front());
      m_acc++;
      if (expq.size() > 0 && m_acc == expq[0].len) m_outv = 1'b1;
    end
  end

  task automatic step();
    exp_t e;
    @(negedge clk);
    if (!rst) begin
      chk("R9/R10 in_ready", {63'd0, in_ready}, {63'd0, !m_outv});
      chk("R9 out_valid", {63'd0, out_valid}, {63'd0, m_outv});
      if (m_outv && out_valid && expq.size() > 0) begin
        e = expq[0];
        chk("R2 opcode", {56'd0, out_opcode}, {56'd0, e.op});
        chk("R4 illegal", {63'd0, out_illegal}, {63'd0, e.ill});
        chk("R3 param count", {62'd0, out_param_cnt}, 64'(e.np));
        chk("R2/R11 source immediate", {63'd0, out_src_imm}, {63'd0, e.simm});
        chk("R2/R11 source pointer", {63'd0, out_src_ptr}, {63'd0, e.sptr});
        chk("R5 source reg", {60'd0, out_src_reg}, 64'(e.sreg));
        chk("R5 source sub", {60'd0, out_src_sub}, 64'(e.ssub));
        chk("R5 dest reg", {60'd0, out_dst_reg}, 64'(e.dreg));
        chk("R5 dest sub", {60'd0, out_dst_sub}, 64'(e.dsub));
        chk("R6 has imm", {63'd0, out_has_imm}, {63'd0, e.has});
        chk("R6 imm size", {62'd0, out_imm_size}, 64'(e.size));
        chk("R7 imm value", out_imm, e.imm);
        chk("R8 length", 64'(out_length), 64'(e.len));
      end
      cyc++;
      in_valid  = (stream.size() > 0) && (in_mode == 0 || (cyc % 3) != 1);
      in_byte   = (stream.size() > 0) ? stream[0] : 8'h5A;
      out_ready = (out_mode == 0) || ((cyc % 4) == 3);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=hung expected=drained");
      summary();
      $finish;
    end
  end

  initial begin
    int expected_records;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset in_ready", {63'd0, in_ready}, 64'd1);
    chk("R1 reset out_valid", {63'd0, out_valid}, 64'd0);

    add_all();
    expected_records = expq.size();
    in_mode = 0; out_mode = 0;
    while (expq.size() > 0) step();

    add_all();
    expected_records += expq.size();
    in_mode = 1; out_mode = 1;
    while (expq.size() > 0) step();

    // reset in the middle of an instruction (R1)
    in_mode = 0; out_mode = 0;
    add('{8'h41, 8'h02, 8'h3E, 8'h11, 8'h44, 8'hCC, 8'hFF});
    repeat (3) step();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    stream.delete();
    expq.delete();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-instruction reset in_ready", {63'd0, in_ready}, 64'd1);
    chk("R1 mid-instruction reset out_valid", {63'd0, out_valid}, 64'd0);
    add('{8'h00});
    expected_records += 1;
    while (expq.size() > 0) step();
    repeat (2) step();

    chk("R3 record count", 64'(records), 64'(expected_records));
    summary();
    $finish;
  end

endmodule